// File: doc/BRIEF.md
# UART Receive Frame Engine

This block recovers asynchronous serial words from a single receive line. It runs from the system clock and takes a sampling strobe at sixteen times the bit rate. On every strobe it looks at the synchronised line. It detects the falling edge of a start bit and decides each bit by voting over three mid-bit samples. It then assembles 8 or 9 data bits, an optional parity bit and one or two stop bits.

Each finished word is handed to the next stage on a single-cycle push strobe. The strobe carries the data together with a framing, a parity and a noise flag for that word. A continuous low line (a break) is reported once, as an all-zero word with the framing flag set. After any word with a bad stop bit, the engine does not hunt for a new start bit until it has seen the line high. An idle output tells the surrounding logic whether a frame is in progress.

Frame settings are static inputs and must be held steady while a frame is on the line.

Top module: `uart_rx_frame`

## Requirements
- R1: `idle_o` is high after reset, in the hunting state and while waiting for the line to return high. It is low from the strobe that detects a start bit until the decision on the last stop bit.
- R2: Samples are numbered 0 to 15 within a bit, where sample 0 is the strobe that first sees the line low. A start bit whose vote over samples 7, 8 and 9 is high is rejected: no word is pushed and the engine returns to hunting.
- R3: Data bits arrive LSB first and land in `data_o[0]` upward. With `nine_bit_i`=1, 9 bits are taken. With `nine_bit_i`=0, 8 bits are taken and `data_o[8]` is 0.
- R4: With `par_en_i`=1, one parity bit follows the data. `perr_o` is set when the count of ones over the data and parity bits is odd for `par_odd_i`=0, or even for `par_odd_i`=1. With `par_en_i`=0 there is no parity bit time and `perr_o` is 0.
- R5: With `two_stop_i`=1 two stop bits are read, otherwise one. A low vote on any stop bit sets `ferr_o` for that word.
- R6: Each bit value is the majority of samples 7, 8 and 9. Any disagreement among those three samples, in any bit of the frame, sets `nerr_o`, and the word is still delivered with the voted values.
- R7: Every accepted frame produces exactly one `push_o` pulse, one clock wide, at the decision on the last stop bit. The data and flags are valid in that same cycle.
- R8: A break (the line held low well beyond one frame) yields one word with data 0 and `ferr_o`=1. `idle_o` is high while the line stays low after it.
- R9: After a word with `ferr_o`=1, a continuing low line is never taken as a start bit. Start detection resumes only after a strobe that sees the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sampling strobe, 16 per bit time |
| nine_bit_i | input | 1 | 1: nine data bits, 0: eight |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| two_stop_i | input | 1 | 1: two stop bits, 0: one |
| rx_i | input | 1 | Serial receive line (asynchronous) |
| idle_o | output | 1 | Receiver is not inside a frame |
| push_o | output | 1 | One-cycle strobe for a completed word |
| data_o | output | 9 | Received word, LSB at bit 0 |
| ferr_o | output | 1 | Framing error for the pushed word |
| perr_o | output | 1 | Parity error for the pushed word |
| nerr_o | output | 1 | Noise seen within the pushed frame |

## Verification
A bit counter that slips by one position shifts every later bit. The pushed word then shows rotated data or a spurious parity or framing flag on that same frame's push. A sample counter off by a position moves the voting window, so a single glitched sample either escapes the noise flag or corrupts the data bit on the next push. A lost wait-for-high state shows up during a break as a second, spurious push within one frame time. A stuck state shows up as `idle_o` failing to return high, or as a missing push within one frame time.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAIT
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff <= '1;
    else         ff <= {ff[STAGES-2:0], d_i};
  end
  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/rx_bit_vote.sv
module rx_bit_vote #(
  parameter int OVS = 16,
  localparam int CW = $clog2(OVS),
  localparam int MID = OVS / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rx_i,
  output logic          decide_o,
  output logic          vote_o,
  output logic          noise_o
);
  logic s_lo, s_mid;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_lo  <= 1'b1;
      s_mid <= 1'b1;
    end else if (tick_i) begin
      if (cnt_i == CW'(MID - 1)) s_lo  <= rx_i;
      if (cnt_i == CW'(MID))     s_mid <= rx_i;
    end
  end
  assign decide_o = tick_i && (cnt_i == CW'(MID + 1));
  assign vote_o   = (s_lo & s_mid) | (s_lo & rx_i) | (s_mid & rx_i);
  assign noise_o  = !((s_lo == s_mid) && (s_mid == rx_i));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          nine_bit_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  input  logic          rx_i,
  output logic          idle_o,
  output logic          push_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o,
  output logic          perr_o,
  output logic          nerr_o
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bit_idx;
  logic [IW-1:0] last_idx;
  logic [DW-1:0] shreg;
  logic          par_bit, stop_idx, nerr, ferr;
  logic          rx_s, decide, vote, noise, bit_end, bad_stop;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  rx_bit_vote #(.OVS(OVS)) u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_i(cnt),
    .rx_i(rx_s), .decide_o(decide), .vote_o(vote), .noise_o(noise)
  );

  assign last_idx = nine_bit_i ? IW'(DW - 1) : IW'(DW - 2);
  assign bit_end  = tick_i && (cnt == CW'(OVS - 1));
  assign bad_stop = ferr || !vote;
  assign idle_o   = (state == S_HUNT) || (state == S_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_HUNT;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      stop_idx <= 1'b0;
      nerr     <= 1'b0;
      ferr     <= 1'b0;
      push_o   <= 1'b0;
      data_o   <= '0;
      ferr_o   <= 1'b0;
      perr_o   <= 1'b0;
      nerr_o   <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (state)
          S_HUNT: if (!rx_s) begin
            state    <= S_START;
            cnt      <= CW'(1);
            bit_idx  <= '0;
            shreg    <= '0;
            stop_idx <= 1'b0;
            nerr     <= 1'b0;
            ferr     <= 1'b0;
          end
          S_WAIT: if (rx_s) state <= S_HUNT;
          default: begin
            cnt <= cnt + CW'(1);
            if (decide) begin
              unique case (state)
                S_START: if (vote) state <= S_HUNT;
                         else nerr <= nerr | noise;
                S_DATA: begin
                  shreg[bit_idx] <= vote;
                  nerr <= nerr | noise;
                end
                S_PAR: begin
                  par_bit <= vote;
                  nerr    <= nerr | noise;
                end
                default: begin
                  if (stop_idx == two_stop_i) begin
                    push_o <= 1'b1;
                    data_o <= shreg;
                    ferr_o <= bad_stop;
                    perr_o <= par_en_i & (^shreg ^ par_bit ^ par_odd_i);
                    nerr_o <= nerr | noise;
                    state  <= bad_stop ? S_WAIT : S_HUNT;
                  end else begin
                    ferr <= bad_stop;
                    nerr <= nerr | noise;
                  end
                end
              endcase
            end
            if (bit_end) begin
              unique case (state)
                S_START: state <= S_DATA;
                S_DATA: begin
                  if (bit_idx == last_idx) state <= par_en_i ? S_PAR : S_STOP;
                  else bit_idx <= bit_idx + IW'(1);
                end
                S_PAR:   state <= S_STOP;
                default: stop_idx <= 1'b1;
              endcase
            end
          end
        endcase
      end
    end
  end

  assert_push_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
  assert_push_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> idle_o);
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_HUNT && tick_i && !rx_s) |=> (state == S_START && !idle_o));
  assert_ferr_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && ferr_o) |-> (state == S_WAIT));
  assert_wait_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_WAIT && !(tick_i && rx_s)) |=> (state == S_WAIT));
  assert_no_parity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !par_en_i) |-> !perr_o);
  assert_eight_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !nine_bit_i) |-> !data_o[DW-1]);
endmodule

// File: tb/sim_uart_rx_frame.sv
module sim_uart_rx_frame;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic nine_bit_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0, two_stop_i = 1'b0;
  logic rx_i = 1'b1;
  logic idle_o, push_o, ferr_o, perr_o, nerr_o;
  logic [8:0] data_o;

  int n_chk = 0, n_bad = 0, n_push = 0;
  logic [8:0] cap_data;
  logic cap_ferr, cap_perr, cap_nerr;
  int div = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_rx_frame u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .nine_bit_i(nine_bit_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .two_stop_i(two_stop_i),
    .rx_i(rx_i), .idle_o(idle_o), .push_o(push_o), .data_o(data_o),
    .ferr_o(ferr_o), .perr_o(perr_o), .nerr_o(nerr_o)
  );

  always @(negedge clk_i) begin
    div    <= (div == 2) ? 0 : div + 1;
    tick_i <= (div == 2);
    if (push_o) begin
      n_push   <= n_push + 1;
      cap_data <= data_o;
      cap_ferr <= ferr_o;
      cap_perr <= perr_o;
      cap_nerr <= nerr_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    rx_i = v;
    @(posedge clk_i);
    while (!tick_i) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic send_bit(input logic v, input int glitch);
    for (int s = 0; s < 16; s++) slot((s == glitch) ? ~v : v);
  endtask

  task automatic idle_bits(input int n);
    for (int b = 0; b < n; b++) send_bit(1'b1, -1);
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low; noise_bit: frame bit index or -1
  task automatic send_frame(input logic [8:0] d, input bit flip_par, input int bad_stop,
                            input int noise_bit, input int gslot);
    int nb, idx;
    logic p;
    nb  = nine_bit_i ? 9 : 8;
    idx = 0;
    send_bit(1'b0, (noise_bit == idx) ? gslot : -1);
    idx++;
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i], (noise_bit == idx) ? gslot : -1);
      idx++;
      if (i == 0) check("R1 idle low in frame", int'(idle_o), 0);
    end
    if (par_en_i) begin
      p = (nine_bit_i ? ^d : ^d[7:0]) ^ par_odd_i ^ flip_par;
      send_bit(p, (noise_bit == idx) ? gslot : -1);
      idx++;
    end
    send_bit(bad_stop == 1 ? 1'b0 : 1'b1, (noise_bit == idx) ? gslot : -1);
    idx++;
    if (two_stop_i) send_bit(bad_stop == 2 ? 1'b0 : 1'b1, (noise_bit == idx) ? gslot : -1);
    idle_bits(2);
  endtask

  initial begin
    int base;
    logic [8:0] d, mask;
    int nfb, nbit, bs;
    bit fp;
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset idle", int'(idle_o), 1);
    check("R7 reset push", int'(push_o), 0);
    rst_ni = 1'b1;
    idle_bits(1);

    for (int cfg = 0; cfg < 16; cfg++) begin
      nine_bit_i = cfg[0];
      par_en_i   = cfg[1];
      par_odd_i  = cfg[2];
      two_stop_i = cfg[3];
      mask = nine_bit_i ? 9'h1FF : 9'h0FF;
      nfb  = 1 + (nine_bit_i ? 9 : 8) + (par_en_i ? 1 : 0) + (two_stop_i ? 2 : 1);
      idle_bits(1);
      for (int w = 0; w < 8; w++) begin
        d = (w == 0) ? 9'h000 : (w == 1) ? 9'h1FF : 9'((w * 73 + cfg * 29 + 5));
        d = d & mask;
        fp   = par_en_i && (w == 3);
        bs   = (w == 5) ? 1 : ((w == 6 && two_stop_i) ? 2 : 0);
        nbit = (w == 2 || w == 7) ? (w + cfg) % nfb : -1;
        base = n_push;
        send_frame(d, fp, bs, nbit, 7 + (w + cfg) % 3);
        check("R7 one push per frame", n_push - base, 1);
        check("R3 data LSB first", int'(cap_data), int'(d));
        check("R4 parity flag", int'(cap_perr), int'(fp));
        check("R5 framing flag", int'(cap_ferr), int'(bs != 0));
        check("R6 noise flag", int'(cap_nerr), int'(nbit >= 0));
        check("R1 idle after frame", int'(idle_o), 1);
      end
    end

    // R2: short low pulse that recovers before mid-bit
    nine_bit_i = 0; par_en_i = 0; par_odd_i = 0; two_stop_i = 0;
    base = n_push;
    for (int s = 0; s < 5; s++) slot(1'b0);
    idle_bits(3);
    check("R2 false start no push", n_push - base, 0);
    check("R2 false start idle", int'(idle_o), 1);

    // R8/R9: long break, then recovery
    base = n_push;
    for (int b = 0; b < 40; b++) begin
      send_bit(1'b0, -1);
      if (b == 20) check("R8 idle high in break wait", int'(idle_o), 1);
    end
    check("R8 break single push", n_push - base, 1);
    check("R8 break data zero", int'(cap_data), 0);
    check("R8 break framing", int'(cap_ferr), 1);
    idle_bits(1);
    base = n_push;
    send_frame(9'h0A5, 1'b0, 0, -1, 8);
    check("R9 recovery push", n_push - base, 1);
    check("R9 recovery data", int'(cap_data), 'hA5);
    check("R9 recovery framing", int'(cap_ferr), 0);

    // R9: bad stop on nonzero data, line stays low afterwards
    base = n_push;
    send_bit(1'b0, -1);
    for (int i = 0; i < 8; i++) send_bit(i[0], -1);
    for (int b = 0; b < 6; b++) send_bit(1'b0, -1);
    check("R9 no restart on low line", n_push - base, 1);
    check("R9 bad stop framing", int'(cap_ferr), 1);
    check("R9 bad stop data", int'(cap_data), 'hAA);
    idle_bits(1);
    send_frame(9'h03C, 1'b0, 0, -1, 8);
    check("R9 next word after high", n_push - base, 2);
    check("R9 next word data", int'(cap_data), 'h3C);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule